// File: doc/BRIEF.md
# Serial Peripheral Byte Controller with Event Flags

This block moves bytes over a four-signal serial link, either as the clock-driving master or as a slave that follows an external clock. Software sees one 8-bit control register, a transmit holding byte and a receive holding byte. The engine uses a single 8-bit shift register, sends MSB first, and uses clock mode 0. In mode 0 the clock idles low, data is sampled on the rising edge and changes after it.

Four event conditions raise sticky flags: end of transfer, write collision, mode fault and slave receive overrun. Each flag stays set until software writes a 0 to it. The interrupt request is the OR of all four flags.

A two-bit select-mode field decides how the select pin is used. It can be ignored (3-wire), treated as an input (4-wire slave or multi-master), or driven as an output (4-wire single master). A separate master bit is written through its own port. The block clears that bit itself when another master pulls the select input low.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the control register reads 0x06 and `irq` is 0. Control register layout: bit7 done, bit6 collision, bit5 mode fault, bit4 overrun, bits3:2 select mode, bit1 transmit-empty, bit0 enable.
- R2: In master mode, a byte in the transmit holding byte is shifted out on `mosi_o`, MSB first. `sck_o` idles low and completes 8 pulses, and `miso_i` is sampled on each rising edge. At the end, the received byte appears on `dat_rdata` and the done flag (bit7) is set.
- R3: A control write of 0 to a flag bit (bits 7:4) clears it. A write of 1 to a flag bit leaves it unchanged. Bit1 ignores writes.
- R4: `irq` is 1 exactly when at least one of bits 7:4 is 1.
- R5: A data write while a transfer is in progress sets the collision flag (bit6). That written byte is discarded.
- R6: Enable=1, master bit=1, select mode 01 and `nss_i` low together set the mode-fault flag (bit5). The master bit then clears, and `sck_oe` and `mosi_oe` drop to 0.
- R7: As a slave, the block follows `sck_i`: it samples `mosi_i` on rising edges and presents its transmit byte MSB first on `miso_o`. The slave is selected while `nss_i` is low in mode 01, and always in mode 00.
- R8: In slave mode, if a byte completes while the receive holding byte is still unread, the overrun flag (bit4) is set. The older received byte is kept.
- R9: Bit1 reads 0 after a data write. It returns to 1 once the byte has moved into the shift register.
- R10: With select mode 1x, `nss_oe` is 1 and `nss_o` equals mode bit 0. No mode fault occurs in this mode. With select mode 0x, `nss_oe` is 0.
- R11: With enable=0 no transfer starts and `sck_oe` is 0. The register still accepts writes. Setting enable to 1 lets a pending byte go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| dat_wr | input | 1 | Transmit holding byte write strobe |
| dat_wdata | input | 8 | Transmit byte |
| dat_rd | input | 1 | Receive byte consumed (clears unread state) |
| dat_rdata | output | 8 | Receive holding byte |
| mst_wr | input | 1 | Master bit write strobe |
| mst_wdata | input | 1 | Master bit value |
| is_master | output | 1 | Current master bit |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data output enable |
| nss_i | input | 1 | Select input |
| nss_o | output | 1 | Select output value |
| nss_oe | output | 1 | Select output enable |

## Verification
The hardest condition to reach is the slave receive overrun. It needs two complete externally clocked bytes with no read of the receive holding byte in between. The check must then show that the first byte survived. The bench acts as an external master, toggling `sck_i` slowly enough for the input synchronizers. It clocks one byte in, deliberately skips `dat_rd`, and clocks a second byte. A write collision is reached the same way, with a data write issued mid-byte during a master transfer.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       done;
    logic       wcol;
    logic       modf;
    logic       ovr;
    logic [1:0] sel;
    logic       txe;
    logic       en;
  } ctl_reg_t;

  localparam ctl_reg_t CTL_RST = '{done: 1'b0, wcol: 1'b0, modf: 1'b0, ovr: 1'b0,
                                   sel: 2'b01, txe: 1'b1, en: 1'b0};

  localparam logic [1:0] SEL_3W  = 2'b00;
  localparam logic [1:0] SEL_MM  = 2'b01;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rst_val,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= rst_val;
      else if (s == 0) stg_q[s] <= d;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output ctl_reg_t     ctl_o,
  input  logic         dat_wr,
  input  logic [W-1:0] dat_wdata,
  input  logic         dat_rd,
  output logic [W-1:0] rx_byte_o,
  output logic [W-1:0] tx_byte_o,
  output logic         tx_pend_o,
  input  logic         mst_wr,
  input  logic         mst_wdata,
  output logic         master_o,
  input  logic         xfer_done,
  input  logic [W-1:0] xfer_byte,
  input  logic         busy,
  input  logic         load_ack,
  input  logic         nss_s
);
  ctl_reg_t     ctl_q, ctl_n;
  logic         mst_q, mst_n;
  logic [W-1:0] txb_q, txb_n;
  logic [W-1:0] rxb_q, rxb_n;
  logic         rxf_q, rxf_n;
  logic         fault, accept, collide;

  assign fault   = ctl_q.en && mst_q && (ctl_q.sel == SEL_MM) && !nss_s;
  assign collide = dat_wr && (busy || load_ack);
  assign accept  = dat_wr && !collide;

  always_comb begin
    ctl_n = ctl_q;
    mst_n = mst_q;
    txb_n = txb_q;
    rxb_n = rxb_q;
    rxf_n = rxf_q;
    if (reg_wr) begin
      ctl_n.done = ctl_q.done & reg_wdata[7];
      ctl_n.wcol = ctl_q.wcol & reg_wdata[6];
      ctl_n.modf = ctl_q.modf & reg_wdata[5];
      ctl_n.ovr  = ctl_q.ovr  & reg_wdata[4];
      ctl_n.sel  = reg_wdata[3:2];
      ctl_n.en   = reg_wdata[0];
    end
    if (mst_wr) mst_n = mst_wdata;
    if (fault) begin
      mst_n      = 1'b0;
      ctl_n.modf = 1'b1;
    end
    if (collide) ctl_n.wcol = 1'b1;
    if (load_ack) ctl_n.txe = 1'b1;
    if (accept) begin
      txb_n     = dat_wdata;
      ctl_n.txe = 1'b0;
    end
    if (dat_rd) rxf_n = 1'b0;
    if (xfer_done) begin
      ctl_n.done = 1'b1;
      if (!mst_q && rxf_q) begin
        ctl_n.ovr = 1'b1;
      end else begin
        rxb_n = xfer_byte;
        rxf_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      mst_q <= 1'b0;
      txb_q <= '0;
      rxb_q <= '0;
      rxf_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      mst_q <= mst_n;
      txb_q <= txb_n;
      rxb_q <= rxb_n;
      rxf_q <= rxf_n;
    end
  end

  assign ctl_o     = ctl_q;
  assign master_o  = mst_q;
  assign tx_byte_o = txb_q;
  assign tx_pend_o = !ctl_q.txe;
  assign rx_byte_o = rxb_q;

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.done && !(reg_wr && !reg_wdata[7]) |=> ctl_q.done);
  assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.ovr && !(reg_wr && !reg_wdata[4]) |=> ctl_q.ovr);
  assert_wcol_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && busy |=> ctl_q.wcol && $stable(txb_q));
  assert_modf_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.en && mst_q && ctl_q.sel == SEL_MM && !nss_s |=> !mst_q && ctl_q.modf);
  assert_txe_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> ctl_q.txe);
  assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !mst_q && rxf_q |=> $stable(rxb_q));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_ctl_pkg::*;
#(
  parameter int unsigned W        = BYTE_W,
  parameter int unsigned DIV_HALF = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic [1:0]   sel,
  input  logic         tx_pend,
  input  logic [W-1:0] tx_byte,
  output logic         load_ack,
  output logic         busy_o,
  output logic         xfer_done,
  output logic [W-1:0] xfer_byte,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic         nss_s,
  input  logic         miso_i,
  output logic         sck_o,
  output logic         sdo_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
  localparam logic [DW-1:0] DIV_TOP  = DW'(DIV_HALF - 1);

  logic          mbusy_q, mbusy_n;
  logic          sck_q, sck_n;
  logic [DW-1:0] div_q, div_n;
  logic [CW-1:0] bit_q, bit_n;
  logic [W-1:0]  sr_q, sr_n;
  logic          rbit_q, rbit_n;
  logic          sckd_q;
  logic          sck_rise, slv_sel;

  assign sck_rise = sck_s && !sckd_q;
  assign slv_sel  = (sel == SEL_3W) || ((sel == SEL_MM) && !nss_s);

  always_comb begin
    mbusy_n   = mbusy_q;
    sck_n     = sck_q;
    div_n     = div_q;
    bit_n     = bit_q;
    sr_n      = sr_q;
    rbit_n    = rbit_q;
    load_ack  = 1'b0;
    xfer_done = 1'b0;
    xfer_byte = {sr_q[W-2:0], rbit_q};
    if (!en) begin
      mbusy_n = 1'b0;
      sck_n   = 1'b0;
      div_n   = '0;
      bit_n   = '0;
    end else if (master) begin
      if (!mbusy_q) begin
        if (tx_pend) begin
          sr_n     = tx_byte;
          mbusy_n  = 1'b1;
          div_n    = '0;
          bit_n    = '0;
          sck_n    = 1'b0;
          load_ack = 1'b1;
        end
      end else if (div_q == DIV_TOP) begin
        div_n = '0;
        sck_n = !sck_q;
        if (!sck_q) begin
          rbit_n = miso_i;
        end else begin
          sr_n = {sr_q[W-2:0], rbit_q};
          if (bit_q == LAST_BIT) begin
            mbusy_n   = 1'b0;
            bit_n     = '0;
            xfer_done = 1'b1;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end
      end else begin
        div_n = div_q + 1'b1;
      end
    end else begin
      mbusy_n = 1'b0;
      sck_n   = 1'b0;
      div_n   = '0;
      if (mbusy_q) begin
        bit_n = '0;
      end else if (slv_sel && sck_rise) begin
        sr_n      = {sr_q[W-2:0], mosi_s};
        xfer_byte = {sr_q[W-2:0], mosi_s};
        if (bit_q == LAST_BIT) begin
          bit_n     = '0;
          xfer_done = 1'b1;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end else begin
        if (!slv_sel) bit_n = '0;
        if (tx_pend && (!slv_sel || bit_q == '0)) begin
          sr_n     = tx_byte;
          load_ack = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy_q <= 1'b0;
      sck_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      sr_q    <= '0;
      rbit_q  <= 1'b0;
      sckd_q  <= 1'b0;
    end else begin
      mbusy_q <= mbusy_n;
      sck_q   <= sck_n;
      div_q   <= div_n;
      bit_q   <= bit_n;
      sr_q    <= sr_n;
      rbit_q  <= rbit_n;
      sckd_q  <= sck_s;
    end
  end

  assign busy_o = mbusy_q || (bit_q != '0);
  assign sck_o  = sck_q;
  assign sdo_o  = sr_q[W-1];

  assert_idle_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_o && !sck_o);
  assert_no_sck_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !sck_o);
  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && master |=> !sck_o && !mbusy_q);
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int unsigned W        = BYTE_W,
  parameter int unsigned DIV_HALF = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic         dat_wr,
  input  logic [W-1:0] dat_wdata,
  input  logic         dat_rd,
  output logic [W-1:0] dat_rdata,
  input  logic         mst_wr,
  input  logic         mst_wdata,
  output logic         is_master,
  output logic         irq,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         mosi_i,
  output logic         mosi_o,
  output logic         mosi_oe,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe,
  input  logic         nss_i,
  output logic         nss_o,
  output logic         nss_oe
);
  logic         rst_a_q, rst_b_q, srst_n;
  ctl_reg_t     ctl;
  logic [2:0]   pin_s;
  logic         sck_s, mosi_s, nss_s;
  logic         master, tx_pend, load_ack, busy, xfer_done, sdo;
  logic [W-1:0] tx_byte, xfer_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign srst_n = rst_b_q;

  spi_sync #(.N(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(srst_n), .rst_val(3'b100),
    .d({nss_i, mosi_i, sck_i}), .q(pin_s)
  );
  assign {nss_s, mosi_s, sck_s} = pin_s;

  spi_ctl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .ctl_o(ctl),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .rx_byte_o(dat_rdata), .tx_byte_o(tx_byte), .tx_pend_o(tx_pend),
    .mst_wr(mst_wr), .mst_wdata(mst_wdata), .master_o(master),
    .xfer_done(xfer_done), .xfer_byte(xfer_byte), .busy(busy),
    .load_ack(load_ack), .nss_s(nss_s)
  );

  spi_shift_eng #(.W(W), .DIV_HALF(DIV_HALF)) u_eng (
    .clk(clk), .rst_n(srst_n),
    .en(ctl.en), .master(master), .sel(ctl.sel),
    .tx_pend(tx_pend), .tx_byte(tx_byte), .load_ack(load_ack),
    .busy_o(busy), .xfer_done(xfer_done), .xfer_byte(xfer_byte),
    .sck_s(sck_s), .mosi_s(mosi_s), .nss_s(nss_s), .miso_i(miso_i),
    .sck_o(sck_o), .sdo_o(sdo)
  );

  assign reg_rdata = ctl;
  assign is_master = master;
  assign irq       = ctl.done | ctl.wcol | ctl.modf | ctl.ovr;
  assign sck_oe    = master && ctl.en;
  assign mosi_oe   = master && ctl.en;
  assign mosi_o    = sdo;
  assign miso_o    = sdo;
  assign miso_oe   = ctl.en && !master &&
                     ((ctl.sel == SEL_3W) || ((ctl.sel == SEL_MM) && !nss_s));
  assign nss_o     = ctl.sel[0];
  assign nss_oe    = ctl.sel[1];

  assert_irq_follow_R4: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_done |=> irq);
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!srst_n)
    reg_wr && reg_wdata[7:4] == 4'h0 && !xfer_done && !dat_wr && !(ctl.en && master && !nss_s) |=> !irq);
endmodule

// File: tb/tb_spi_ctl_top.sv
`timescale 1ns/1ps
module tb_spi_ctl_top;
  logic       clk, rst_n;
  logic       reg_wr, dat_wr, dat_rd, mst_wr, mst_wdata;
  logic [7:0] reg_wdata, reg_rdata, dat_wdata, dat_rdata;
  logic       is_master, irq;
  logic       sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
  logic       miso_o, miso_oe, nss_i, nss_o, nss_oe;
  logic       loopback, tb_miso, miso_w;
  int         n_chk, n_fail;

  assign miso_w = loopback ? mosi_o : tb_miso;

  spi_ctl_top dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .mst_wr(mst_wr), .mst_wdata(mst_wdata), .is_master(is_master), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_w), .miso_o(miso_o), .miso_oe(miso_oe),
    .nss_i(nss_i), .nss_o(nss_o), .nss_oe(nss_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic set_mst(input logic v);
    @(negedge clk); mst_wr = 1'b1; mst_wdata = v;
    @(negedge clk); mst_wr = 1'b0;
  endtask

  task automatic rd_dat();
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !reg_rdata[7]; i++) @(negedge clk);
  endtask

  task automatic slave_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = b[i];
      repeat (8) @(negedge clk);
      sck_i  = 1'b1;
      got[i] = miso_o;
      repeat (8) @(negedge clk);
      sck_i  = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset ctl", reg_rdata, 8'h06);
    check("R1 reset irq", irq, 0);
    check("R10 nss_oe in mode 01", nss_oe, 0);
  endtask

  task automatic t_master_loop();
    loopback = 1'b1;
    set_mst(1'b1);
    wr_ctl(8'h05);
    wr_dat(8'hA5);
    check("R9 txe low after write", reg_rdata[1], 0);
    @(negedge clk);
    check("R9 txe high after load", reg_rdata[1], 1);
    check("R2 sck_oe as master", sck_oe, 1);
    wait_done();
    check("R2 done flag", reg_rdata[7], 1);
    check("R2 loopback byte", dat_rdata, 8'hA5);
    check("R4 irq with done", irq, 1);
    wr_ctl(8'hF5);
    check("R3 write 1 keeps done", reg_rdata[7], 1);
    wr_ctl(8'h05);
    check("R3 write 0 clears done", reg_rdata, 8'h07);
    check("R4 irq low when clear", irq, 0);
    wr_ctl(8'hF5);
    check("R3 write 1 ignored, txe readonly", reg_rdata, 8'h07);
  endtask

  task automatic t_master_miso();
    logic [7:0] pat;
    pat = 8'h3B;
    loopback = 1'b0;
    rd_dat();
    wr_dat(8'h00);
    for (int i = 7; i >= 0; i--) begin
      tb_miso = pat[i];
      while (sck_o !== 1'b1) @(negedge clk);
      while (sck_o !== 1'b0) @(negedge clk);
    end
    wait_done();
    check("R2 miso sampled byte", dat_rdata, 8'h3B);
    wr_ctl(8'h05);
    loopback = 1'b1;
  endtask

  task automatic t_collision();
    wr_dat(8'h96);
    repeat (10) @(negedge clk);
    wr_dat(8'h0F);
    check("R5 collision flag", reg_rdata[6], 1);
    check("R4 irq with collision", irq, 1);
    wait_done();
    check("R5 collided byte discarded", dat_rdata, 8'h96);
    check("R5 txe unchanged by collision", reg_rdata[1], 1);
    wr_ctl(8'h05);
    check("R3 clear collision", reg_rdata, 8'h07);
  endtask

  task automatic t_mode_fault();
    nss_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 mode fault flag", reg_rdata[5], 1);
    check("R6 master dropped", is_master, 0);
    check("R6 sck_oe off", sck_oe, 0);
    check("R6 mosi_oe off", mosi_oe, 0);
    nss_i = 1'b1;
    repeat (4) @(negedge clk);
    wr_ctl(8'h05);
    check("R3 clear mode fault", reg_rdata, 8'h07);
  endtask

  task automatic t_single_master();
    wr_ctl(8'h0D);
    check("R10 nss_oe mode 11", nss_oe, 1);
    check("R10 nss_o mode 11", nss_o, 1);
    wr_ctl(8'h09);
    check("R10 nss_o mode 10", nss_o, 0);
    set_mst(1'b1);
    nss_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 no fault in mode 10", reg_rdata[5], 0);
    check("R10 master kept", is_master, 1);
    nss_i = 1'b1;
    set_mst(1'b0);
    wr_ctl(8'h05);
  endtask

  task automatic t_slave();
    logic [7:0] got;
    rd_dat();
    wr_dat(8'h3C);
    @(negedge clk);
    check("R9 slave txe after load", reg_rdata[1], 1);
    nss_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 miso_oe when selected", miso_oe, 1);
    slave_byte(8'hC3, got);
    check("R7 slave shifted out", got, 8'h3C);
    check("R7 slave received", dat_rdata, 8'hC3);
    check("R7 slave done", reg_rdata[7], 1);
    slave_byte(8'h55, got);
    check("R8 overrun flag", reg_rdata[4], 1);
    check("R8 older byte kept", dat_rdata, 8'hC3);
    nss_i = 1'b1;
    repeat (4) @(negedge clk);
    rd_dat();
    wr_ctl(8'h01);
    check("R3 clear slave flags", reg_rdata, 8'h03);
    slave_byte(8'h81, got);
    check("R7 3-wire slave receive", dat_rdata, 8'h81);
    check("R8 no overrun after read", reg_rdata[4], 0);
    wr_ctl(8'h05);
  endtask

  task automatic t_disabled();
    loopback = 1'b1;
    rd_dat();
    wr_ctl(8'h04);
    set_mst(1'b1);
    wr_dat(8'h6E);
    repeat (100) @(negedge clk);
    check("R11 no transfer when off", reg_rdata[7], 0);
    check("R11 byte still pending", reg_rdata[1], 0);
    check("R11 sck_oe off", sck_oe, 0);
    wr_ctl(8'h05);
    check("R11 register writable", reg_rdata[0], 1);
    wait_done();
    check("R11 transfer after enable", dat_rdata, 8'h6E);
    wr_ctl(8'h05);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; dat_wr = 1'b0; dat_wdata = '0;
    dat_rd = 1'b0; mst_wr = 1'b0; mst_wdata = 1'b0;
    sck_i = 1'b0; mosi_i = 1'b0; nss_i = 1'b1; loopback = 1'b1; tb_miso = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master_loop();
    t_master_miso();
    t_collision();
    set_mst(1'b1);
    t_mode_fault();
    t_single_master();
    t_slave();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule